// File: doc/BRIEF.md
# Serial Audio Data Port

This block moves audio words between a parallel word interface and a single serial data line. Its bit clock either comes from an internal divider or from an external pin. The internal divider runs from the system clock `clk`. That clock runs at twice the oversampling rate, so a half-period of 2^k system cycles gives a bit clock of the oversampling rate divided by 2^k. An external bit clock on `sck_i` is synchronised and edge-detected instead. All logic sits in the single `clk` domain and acts on one-cycle rise and fall strobes.

One 8-bit control register sets the behaviour. It selects transmit or receive, mute, compressed operation, burst clock gating, the bit-clock source and the divide code. A framing counter toggles `ws_o` at every word boundary. In transmit mode, words are taken through a valid/ready pair, one word per boundary. In receive mode, each assembled word appears with a one-cycle strobe. Burst gating applies only in compressed transmit with the internal clock. Under burst gating the bit clock rests low between words and runs exactly one word's worth of pulses per word.

Control register layout: bit 0 transmit (1) / receive (0), bit 1 mute, bit 2 compressed, bit 3 burst, bit 4 internal bit clock (1) / external (0), bits 7:5 divide code.

Top module: `ser_audio_port`

## Requirements
- R1: After reset the control register is zero (receive mode, external clock, divide code 0), and `sck_o`, `sck_oe`, `sd_o`, `ws_o`, `cfg_err`, `tx_ready` and `rx_valid` are all 0.
- R2: With bit 4 set and divide code k in 0..4 (bits 7:5), `sck_o` toggles every 2^k `clk` cycles, so consecutive rising edges are 2^(k+1) cycles apart, and `sck_oe` is 1.
- R3: Writing divide code 5, 6 or 7 keeps the previous ratio, sets `cfg_err`, and `cfg_err` then stays 1 until reset; later legal codes still change the ratio.
- R4: With bit 4 clear, `sck_o` and `sck_oe` stay 0 and the divide code has no effect; words move on the edges of `sck_i`, which are seen through a two-stage synchroniser.
- R5: In transmit mode (bit 0 = 1), words leave MSB first. `sd_o` changes only in the cycle where the bit clock falls. `tx_ready` is high in the cycle of the falling edge that ends a word, a word is taken when `tx_valid` and `tx_ready` are both high at a `clk` edge, and a boundary with no word sends an all-zero word.
- R6: In receive mode (bit 0 = 0), `sd_i` is sampled at each rising bit-clock edge, MSB first. `rx_valid` pulses for one cycle just after the rising edge that carries a word's last bit, and `rx_data` then holds that word.
- R7: With mute (bit 1) in transmit mode, `sd_o` stays low while words are still taken at each boundary.
- R8: `ws_o` toggles at every word-boundary falling edge, i.e. every WORD_W bit periods. While compressed operation is active (bit 2 with bit 0), `ws_o` is held low.
- R9: Burst gating is active when bits 3, 2, 0 and 4 are all set. With no word pending, `sck_o` rests low, `sd_o` is low and `tx_ready` stays high. A word is taken at once, and exactly WORD_W rising edges follow it.
- R10: The burst bit has no effect unless compressed transmit with the internal clock is selected, and the bit clock then keeps running with no word pending.
- R11: In receive mode `sd_o` is held low and `tx_ready` is never asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the oversampling rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write value |
| cfg_err | output | 1 | Sticky flag: a prohibited divide code was written |
| sck_i | input | 1 | External bit clock |
| sck_o | output | 1 | Generated bit clock |
| sck_oe | output | 1 | High when `sck_o` is driven by the block |
| ws_o | output | 1 | Word-select framing output |
| sd_i | input | 1 | Serial data in |
| sd_o | output | 1 | Serial data out |
| tx_data | input | WORD_W | Word to transmit |
| tx_valid | input | 1 | `tx_data` is valid |
| tx_ready | output | 1 | Block takes a word at the next `clk` edge if valid |
| rx_data | output | WORD_W | Last received word |
| rx_valid | output | 1 | One-cycle strobe: `rx_data` updated |

## Verification
Each result has its own due cycle after a stimulus.
- A control write takes effect at the `clk` edge that samples `cfg_we`.
- `sck_o` and `sd_o` move together at the edge where the divider reaches its limit.
- `rx_valid` rises at the edge of the last rising bit-clock strobe.
- With the external clock, every action comes about three `clk` cycles after the `sck_i` transition.

The bench samples all outputs on the falling edge of `clk`. It measures bit-clock periods from the cycles at which it sees rising edges, so it never needs a fixed offset. Serial bits are taken at each observed bit-clock rise, where `sd_o` has been stable for half a bit period. Words are matched against a queue that is filled at the falling `clk` edge before each handshake.

// File: rtl/sap_pkg.sv
package sap_pkg;

    // Control register image; packed order is bit 7 down to bit 0.
    typedef struct packed {
        logic [2:0] div;      // bits 7:5 divide code
        logic       sck_int;  // bit 4: 1 = internal bit clock
        logic       burst;    // bit 3: burst clock gating
        logic       comp;     // bit 2: compressed operation
        logic       mute;     // bit 1: force data low in transmit
        logic       tx;       // bit 0: 1 = transmit, 0 = receive
    } cfg_t;

endpackage

// File: rtl/sap_ctl.sv
module sap_ctl
    import sap_pkg::*;
#(
    parameter int MAX_DIV_CODE = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] wdata,
    output cfg_t       cfg_q,
    output logic       err_o
);

    typedef struct packed {
        cfg_t cfg;
        logic err;
    } ctl_st_t;

    ctl_st_t s_d, s_q;
    cfg_t    wr_cfg;

    always_comb begin
        s_d    = s_q;
        wr_cfg = cfg_t'(wdata);
        if (we) begin
            s_d.cfg = wr_cfg;
            if (wr_cfg.div > 3'(MAX_DIV_CODE)) begin
                s_d.cfg.div = s_q.cfg.div;
                s_d.err     = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cfg_q = s_q.cfg;
    assign err_o = s_q.err;

    // R3: a prohibited code leaves the ratio untouched and flags it
    assert_bad_div_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (wdata[7:5] > 3'(MAX_DIV_CODE))) |=> (cfg_q.div == $past(cfg_q.div)) && err_o);

    // R3: the error flag never clears outside reset
    assert_err_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    // R2: the stored ratio is always a legal one
    assert_div_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.div <= 3'(MAX_DIV_CODE));

endmodule

// File: rtl/sap_clkgen.sv
module sap_clkgen #(
    parameter int MAX_DIV_CODE = 4,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck_int,
    input  logic [2:0] div,
    input  logic       stall,
    input  logic       sck_i,
    output logic       sck_o,
    output logic       rise,
    output logic       fall
);

    localparam int CW = (MAX_DIV_CODE > 0) ? MAX_DIV_CODE : 1;
    localparam int SW = SYNC_STAGES + 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          sck;
        logic [SW-1:0] sync;
    } cg_st_t;

    cg_st_t        s_d, s_q;
    logic [CW-1:0] lim;
    logic          tog;

    always_comb begin
        s_d      = s_q;
        lim      = CW'((32'd1 << div) - 32'd1);
        tog      = 1'b0;
        rise     = 1'b0;
        fall     = 1'b0;
        s_d.sync = {s_q.sync[SW-2:0], sck_i};
        if (sck_int) begin
            tog     = !stall && (s_q.cnt >= lim);
            s_d.cnt = (stall || tog) ? '0 : s_q.cnt + 1'b1;
            s_d.sck = s_q.sck ^ tog;
            rise    = tog && !s_q.sck;
            fall    = tog && s_q.sck;
        end else begin
            s_d.cnt = '0;
            s_d.sck = 1'b0;
            rise    = s_q.sync[SW-2] && !s_q.sync[SW-1];
            fall    = !s_q.sync[SW-2] && s_q.sync[SW-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sck_o = s_q.sck;

    // R4: the output pin is quiet when the clock comes from outside
    assert_ext_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_int |=> !sck_o);

    // R9: a stalled low clock does not move
    assert_stall_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !sck_o) |=> !sck_o);

endmodule

// File: rtl/sap_shift.sv
module sap_shift #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_mode,
    input  logic              mute,
    input  logic              comp_eff,
    input  logic              burst_eff,
    input  logic              rise,
    input  logic              fall,
    input  logic              sck_lvl,
    input  logic              tx_valid,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              sd_i,
    output logic              tx_ready,
    output logic              sd_o,
    output logic              ws_o,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              busy_o,
    output logic              stall_o
);

    localparam int BW = (WORD_W > 2) ? $clog2(WORD_W) : 1;

    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic [BW-1:0]     rem;
        logic              busy;
        logic              ws;
        logic [WORD_W-1:0] rxsh;
        logic [WORD_W-1:0] rxw;
        logic              rxv;
    } sh_st_t;

    sh_st_t s_d, s_q;
    logic   word_end;
    logic   idle_burst;
    logic   take;

    always_comb begin
        s_d        = s_q;
        s_d.rxv    = 1'b0;
        word_end   = fall && (s_q.rem == '0);
        idle_burst = burst_eff && !s_q.busy && !sck_lvl;
        tx_ready   = tx_mode && (word_end || idle_burst);
        take       = tx_ready && tx_valid;
        if (word_end) begin
            s_d.rem = BW'(WORD_W - 1);
            s_d.ws  = ~s_q.ws;
            if (tx_mode) begin
                s_d.sh   = take ? tx_data : '0;
                s_d.busy = take;
            end else begin
                s_d.busy = 1'b1;
            end
        end else if (fall) begin
            s_d.sh  = {s_q.sh[WORD_W-2:0], 1'b0};
            s_d.rem = s_q.rem - 1'b1;
        end else if (take) begin
            s_d.sh   = tx_data;
            s_d.busy = 1'b1;
            s_d.rem  = BW'(WORD_W - 1);
        end
        if (comp_eff) s_d.ws = 1'b0;
        if (rise && !tx_mode) begin
            s_d.rxsh = {s_q.rxsh[WORD_W-2:0], sd_i};
            if ((s_q.rem == '0) && s_q.busy) begin
                s_d.rxw = {s_q.rxsh[WORD_W-2:0], sd_i};
                s_d.rxv = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sd_o     = tx_mode && !mute && s_q.sh[WORD_W-1];
    assign ws_o     = s_q.ws;
    assign rx_data  = s_q.rxw;
    assign rx_valid = s_q.rxv;
    assign busy_o   = s_q.busy;
    assign stall_o  = idle_burst;

    // R9: an idle gated line carries no data
    assert_idle_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_eff && !s_q.busy) |-> !sd_o);

    // R8: framing output is held low under compressed operation
    assert_ws_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (comp_eff && $past(comp_eff)) |-> !ws_o);

    // R11: no received word is reported while transmitting
    assert_rx_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tx_mode) |-> !rx_valid);

endmodule

// File: rtl/ser_audio_port.sv
module ser_audio_port
    import sap_pkg::*;
#(
    parameter int WORD_W       = 16,
    parameter int MAX_DIV_CODE = 4,
    parameter int SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    output logic              cfg_err,
    input  logic              sck_i,
    output logic              sck_o,
    output logic              sck_oe,
    output logic              ws_o,
    input  logic              sd_i,
    output logic              sd_o,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid
);

    cfg_t cfg;
    logic comp_eff, burst_eff;
    logic rise, fall, stall, busy;

    sap_ctl #(.MAX_DIV_CODE(MAX_DIV_CODE)) u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg_q (cfg),
        .err_o (cfg_err)
    );

    assign comp_eff  = cfg.comp && cfg.tx;
    assign burst_eff = cfg.burst && comp_eff && cfg.sck_int;
    assign sck_oe    = cfg.sck_int;

    sap_clkgen #(.MAX_DIV_CODE(MAX_DIV_CODE), .SYNC_STAGES(SYNC_STAGES)) u_clkgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck_int (cfg.sck_int),
        .div     (cfg.div),
        .stall   (stall),
        .sck_i   (sck_i),
        .sck_o   (sck_o),
        .rise    (rise),
        .fall    (fall)
    );

    sap_shift #(.WORD_W(WORD_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_mode   (cfg.tx),
        .mute      (cfg.mute),
        .comp_eff  (comp_eff),
        .burst_eff (burst_eff),
        .rise      (rise),
        .fall      (fall),
        .sck_lvl   (sck_o),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .sd_i      (sd_i),
        .tx_ready  (tx_ready),
        .sd_o      (sd_o),
        .ws_o      (ws_o),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .busy_o    (busy),
        .stall_o   (stall)
    );

    // R9: with gating active and nothing in flight, the clock rests low
    assert_gate_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_eff && !busy && !sck_o) |=> !sck_o);

endmodule

// File: tb/ser_audio_port_bench.sv
module ser_audio_port_bench;

    localparam int W        = 16;
    localparam int EXT_HALF = 6;
    localparam int LIMIT    = 150000;

    logic         clk = 0, rst_n = 0, cfg_we = 0, sck_i = 0, sd_i = 0, tx_valid = 0;
    logic [7:0]   cfg_wdata = 0;
    logic [W-1:0] tx_data = 0;
    logic         cfg_err, sck_o, sck_oe, ws_o, sd_o, tx_ready, rx_valid;
    logic [W-1:0] rx_data;

    ser_audio_port #(.WORD_W(W)) u_ser_audio_port (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_err(cfg_err),
        .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .ws_o(ws_o), .sd_i(sd_i), .sd_o(sd_o),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid)
    );

    always #4 clk = ~clk;  // 125 MHz

    int checks = 0, errors = 0, cyc = 0;
    int mon_mode = 0, words_done = 0, nbits = 0, n_rise = 0, hs_cnt = 0, ridx = W, vprob = 50;
    bit drv_en = 0, ext_en = 0, b_mute = 0, b_burst = 0, in_word = 0, hs = 0;
    logic bprev = 0, sprev = 0, ws_prev = 0, bclk;
    logic [W-1:0] word = 0, rword = 0, ew;
    logic [W-1:0] expq[$], rxq[$];
    string mon_tag = "R5";
    int ext_cnt = 0;

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic byte cfgb(bit tx, bit mute, bit comp, bit burst, bit intclk, int code);
        return byte'({code[2:0], intclk, burst, comp, mute, tx});
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > LIMIT) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, LIMIT);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // external bit clock source
    always @(posedge clk) begin
        #1;
        if (!ext_en) begin sck_i = 0; ext_cnt = 0; end
        else if (++ext_cnt == EXT_HALF) begin ext_cnt = 0; sck_i = ~sck_i; end
    end

    // word source: data changes only after a handshake edge
    always begin
        @(negedge clk);
        hs = tx_valid && tx_ready;
        @(posedge clk); #1;
        if (!drv_en) tx_valid = 0;
        else if (hs || !tx_valid) begin
            tx_valid = ($urandom_range(99) < vprob);
            tx_data  = W'($urandom);
        end
    end

    // monitor and receive driver, sampled away from the active edge
    always @(negedge clk) begin
        bclk = ext_en ? sck_i : sck_o;
        if (sck_o && !sprev) n_rise++;
        sprev = sck_o;
        if (mon_mode == 1) begin
            if (bclk && !bprev && in_word) begin
                word = {word[W-2:0], sd_o};
                nbits++;
                if (nbits == W) begin
                    if (expq.size() == 0) chk(0, {mon_tag, " word with no expectation"}, word, 0);
                    else begin
                        ew = expq.pop_front();
                        chk(word == ew, {mon_tag, " serial word"}, word, ew);
                    end
                    words_done++;
                    in_word = 0;
                end
            end
            if (tx_ready) begin
                if (tx_valid) begin
                    expq.push_back(b_mute ? '0 : tx_data);
                    hs_cnt++; in_word = 1; nbits = 0;
                end else if (!b_burst) begin
                    expq.push_back('0); in_word = 1; nbits = 0;
                end
                if (b_burst && !sck_o) chk(sd_o == 0, "R9 idle data low", sd_o, 0);
            end
        end
        if (mon_mode == 2) begin
            if (!bclk && bprev) begin
                if (ws_o != ws_prev) begin
                    rword = W'($urandom); rxq.push_back(rword); ridx = 0;
                end else ridx++;
                sd_i = (ridx < W) ? rword[W-1-ridx] : 1'b0;
            end
            if (rx_valid) begin
                if (rxq.size() == 0) chk(0, "R6 unexpected word", rx_data, 0);
                else begin
                    ew = rxq.pop_front();
                    chk(rx_data == ew, "R6 received word", rx_data, ew);
                end
                chk(sd_o == 0 && tx_ready == 0, "R11 receive keeps sd_o and tx_ready low",
                    {sd_o, tx_ready}, 0);
                words_done++;
            end
            ws_prev = ws_o;
        end
        bprev = bclk;
    end

    task automatic do_reset();
        mon_mode = 0; drv_en = 0; ext_en = 0; b_mute = 0; b_burst = 0;
        rst_n = 0; cfg_we = 0; sd_i = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        expq.delete(); rxq.delete();
        in_word = 0; words_done = 0; hs_cnt = 0; ws_prev = 0; ridx = W; rword = 0;
    endtask

    task automatic wcfg(byte v);
        @(posedge clk); #1 cfg_we = 1; cfg_wdata = v;
        @(posedge clk); #1 cfg_we = 0;
    endtask

    task automatic wait_rise(output int t);
        logic pv;
        pv = sck_o;
        forever begin
            @(negedge clk);
            if (sck_o && !pv) begin t = cyc; return; end
            pv = sck_o;
        end
    endtask

    task automatic wait_ws(output int t);
        logic pv;
        pv = ws_o;
        forever begin
            @(negedge clk);
            if (ws_o != pv) begin t = cyc; return; end
        end
    endtask

    task automatic period_chk(int exp, string tag);
        int t0, t1;
        wait_rise(t0);
        for (int i = 0; i < 3; i++) begin
            wait_rise(t1);
            chk(t1 - t0 == exp, tag, t1 - t0, exp);
            t0 = t1;
        end
    endtask

    task automatic wait_words(int n);
        while (words_done < n) @(negedge clk);
    endtask

    initial begin
        int t0, t1, r0, code;
        void'($urandom(32'h5A17));

        // R1 reset state
        do_reset();
        @(negedge clk);
        chk({sck_o, sck_oe, sd_o, ws_o, cfg_err, tx_ready, rx_valid} == 0,
            "R1 reset outputs", {sck_o, sck_oe, sd_o, ws_o, cfg_err, tx_ready, rx_valid}, 0);

        // R2 every legal divide code
        for (int k = 0; k <= 4; k++) begin
            do_reset();
            wcfg(cfgb(1, 0, 0, 0, 1, k));
            period_chk(2 << k, "R2 bit clock period");
            chk(sck_oe == 1, "R2 clock drive enable", sck_oe, 1);
        end

        // R3 prohibited codes keep the ratio and set the sticky flag
        do_reset();
        wcfg(cfgb(1, 0, 0, 0, 1, 2));
        period_chk(8, "R3 legal ratio before bad write");
        for (int k = 5; k <= 7; k++) begin
            wcfg(cfgb(1, 0, 0, 0, 1, k));
            @(negedge clk);
            chk(cfg_err == 1, "R3 error flag set", cfg_err, 1);
            period_chk(8, "R3 ratio kept");
        end
        wcfg(cfgb(1, 0, 0, 0, 1, 1));
        period_chk(4, "R3 later legal ratio");
        chk(cfg_err == 1, "R3 error flag sticky", cfg_err, 1);

        // R5 / R8 random transmit runs
        for (int run = 0; run < 3; run++) begin
            do_reset();
            code = $urandom_range(3);
            vprob = 40 + $urandom_range(60);
            mon_tag = "R5";
            wcfg(cfgb(1, 0, 0, 0, 1, code));
            mon_mode = 1; drv_en = 1;
            if (run == 0) begin
                wait_ws(t0);
                for (int i = 0; i < 2; i++) begin
                    wait_ws(t1);
                    chk(t1 - t0 == W * (2 << code), "R8 ws toggle interval", t1 - t0, W * (2 << code));
                    t0 = t1;
                end
            end
            wait_words(8);
        end

        // R7 mute: zeros on the line, words still consumed
        do_reset();
        vprob = 80; b_mute = 1; mon_tag = "R7";
        wcfg(cfgb(1, 1, 0, 0, 1, 0));
        mon_mode = 1; drv_en = 1;
        wait_words(6);
        chk(hs_cnt > 0, "R7 words consumed while muted", hs_cnt, 1);

        // R9 burst gating with random gaps
        do_reset();
        vprob = 30; b_burst = 1; mon_tag = "R9";
        wcfg(cfgb(1, 0, 1, 1, 1, 1));
        mon_mode = 1; drv_en = 1;
        wait_words(8);
        chk(ws_o == 0, "R8 ws held low when compressed", ws_o, 0);
        drv_en = 0;
        repeat (W * 8 + 20) @(negedge clk);
        r0 = n_rise;
        repeat (300) @(negedge clk);
        chk(n_rise == r0, "R9 no clock pulses while idle", n_rise - r0, 0);
        chk(sck_o == 0 && sd_o == 0 && tx_ready == 1, "R9 idle levels",
            {sck_o, sd_o, tx_ready}, 1);

        // R10 burst bit without compressed mode, and in receive mode
        do_reset();
        wcfg(cfgb(1, 0, 0, 1, 1, 0));
        r0 = n_rise;
        repeat (200) @(negedge clk);
        chk(n_rise - r0 > 20, "R10 clock runs without compressed", n_rise - r0, 50);
        wcfg(cfgb(0, 0, 1, 1, 1, 0));
        r0 = n_rise;
        repeat (200) @(negedge clk);
        chk(n_rise - r0 > 20, "R10 clock runs in receive", n_rise - r0, 50);

        // R6 / R11 receive
        do_reset();
        wcfg(cfgb(0, 0, 0, 0, 1, 1));
        mon_mode = 2;
        wait_words(10);
        chk(rxq.size() <= 1, "R6 no word lost", rxq.size(), 1);

        // R4 external clock, divide code ignored
        do_reset();
        vprob = 70; mon_tag = "R4";
        wcfg(cfgb(1, 0, 0, 0, 0, 4));
        ext_en = 1; mon_mode = 1; drv_en = 1;
        r0 = n_rise;
        wait_words(6);
        chk(n_rise == r0 && sck_oe == 0, "R4 output clock idle", n_rise - r0, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule